// File: doc/BRIEF.md
# Interleaved Multiphase PWM Generator

This block drives up to four pulse-width-modulated channels of a multiphase buck converter from one shared duty word. A single master counter defines the channel period; every channel in use sees its own copy of that count, shifted by an equal fraction of the period, so the active channels fire evenly spread in time. The converter's ripple then repeats at the channel frequency multiplied by the number of channels in use.

The number of channels is found during reset from per-channel inputs that report a PWM line held high from outside. An unused channel is one whose line is tied high. Each channel adds a signed correction of its own to the shared duty word. This lets an outer current-balancing loop shorten the pulse of a channel that carries more than its share. The corrected value is clamped to what fits in one period. It is taken into the channel only when that channel's own count wraps, so a pulse is never cut or stretched by a change in the middle of a period.

Every line has a separate drive enable, so it can be left floating. The lines float in reset and while disabled. A forced-low mode keeps the active lines driven low, which turns the low-side switches on.

Top module: `mphase_pwm`

## Requirements
- R1: The active channel count is the index (counting from zero) of the lowest tied-high flag among bits 2 and up of `tied_hi_i`, or `NUM_CH` when none of them is set. Channels 0 and 1 are always active. With four channels, bit 3 alone set gives 3, and bit 2 set gives 2. `nch_o` reports the count.
- R2: The channel count is taken only while `rst_n` is low. After reset it does not change, whatever `tied_hi_i` does.
- R3: While running, the master count goes 0,1,…,P-1 and wraps. P is `period_i`, which is captured while disabled and again at each wrap. `cyc_start_o` is high exactly in the cycles where the master count is 0 while running. The first running cycle has master count 0.
- R4: Active channel k lags channel 0 by floor(k·P/n) clocks, where n is the active count. Its local count is (master − floor(k·P/n)) mod P.
- R5: An active channel's line is high while its local count is below its latched duty value, and low otherwise.
- R6: A channel's duty is `duty_cmd_i` plus its signed two's-complement correction, taken from bits [k·CORR_W +: CORR_W] of `duty_corr_i`. The result is clamped to 0..P-1. A duty of 0 gives no pulse at all.
- R7: While running, a channel takes in a new duty value only on the clock where its local count is P-1, so the value applies from local count 0. While disabled, the latched value follows the corrected command on every clock.
- R8: While `rst_n` is low, and in running cycles after `en_i` has been low at a clock edge, every drive enable is low and every line is low.
- R9: While `force_low_i` is high and the block is running, each active channel has its drive enable high and its line low.
- R10: A channel at or above the active count never has its drive enable or its line high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset. The channel count is sampled while it is low. |
| en_i | input | 1 | Run enable; takes effect one clock later |
| force_low_i | input | 1 | Drive all active lines low |
| period_i | input | CNT_W | Channel period in clocks (at least 2) |
| duty_cmd_i | input | CNT_W | Shared duty command in clocks |
| duty_corr_i | input | NUM_CH*CORR_W | Signed per-channel duty corrections, channel k in slice k |
| tied_hi_i | input | NUM_CH | Per-channel flag: line is held high from outside |
| pwm_o | output | NUM_CH | PWM lines |
| pwm_oe_o | output | NUM_CH | Per-line drive enable (0 = floating) |
| cyc_start_o | output | 1 | High in the cycle where the master count is 0 |
| nch_o | output | $clog2(NUM_CH+1) | Active channel count |

## Verification
The assertions assume that `period_i` is at least 2 whenever it can be captured. They also assume that the corrections are no wider than the count. They do not expect the local counts to stay continuous when the period changes at a wrap. The stimulus therefore sets the period and tied flags before reset is released, and keeps the period fixed for the whole of each run. Only the duty command, the force-low control, the enable and the tied flags change while running. The tied-flag change is there to show that the count does not follow it.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;

   localparam int MIN_CH     = 2;
   localparam int MAX_CH     = 4;
   localparam int MIN_PERIOD = 2;

   // How one line is driven in the current cycle
   typedef enum logic [1:0] {
      DRV_FLOAT = 2'd0,
      DRV_LOW   = 2'd1,
      DRV_PWM   = 2'd2
   } drv_mode_e;

endpackage

// File: rtl/mpwm_phase_ctl.sv
module mpwm_phase_ctl
   import mpwm_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int CNT_W  = 8,
   localparam int CW    = $clog2(NUM_CH + 1)
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           en_i,
   input  logic [CNT_W-1:0]               period_i,
   input  logic [NUM_CH-1:0]              tied_i,
   output logic                           run_o,
   output logic [CNT_W-1:0]               mcnt_o,
   output logic [CNT_W-1:0]               per_o,
   output logic [CW-1:0]                  nch_o,
   output logic [NUM_CH-1:0][CNT_W-1:0]   off_o
);

   localparam int PW = CNT_W + 2;

   logic              run_q;
   logic [CNT_W-1:0]  m_q;
   logic [CNT_W-1:0]  per_q;
   logic [CW-1:0]     n_q;
   logic [CW-1:0]     det;
   logic              wrap;

   // lowest tied flag at index 2 or above sets the count
   always_comb begin
      det = CW'(NUM_CH);
      for (int i = NUM_CH - 1; i >= MIN_CH; i--) begin
         if (tied_i[i]) det = CW'(i);
      end
   end

   assign wrap = (m_q == per_q - CNT_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         m_q   <= '0;
         per_q <= period_i;
         n_q   <= det;
      end else begin
         run_q <= en_i;
         if (!run_q || wrap) begin
            m_q   <= '0;
            per_q <= period_i;
         end else begin
            m_q <= m_q + CNT_W'(1);
         end
      end
   end

   // per-channel lag: floor(k*P/n)
   for (genvar k = 0; k < NUM_CH; k++) begin : g_off
      if (k == 0) begin : g_lead
         assign off_o[k] = '0;
      end else begin : g_lag
         logic [PW-1:0] prod;
         logic [PW-1:0] quo;
         assign prod = {2'b00, per_q} * PW'(k);
         always_comb begin
            case (n_q)
               CW'(2):  quo = prod >> 1;
               CW'(3):  quo = prod / PW'(3);
               default: quo = prod >> 2;
            endcase
         end
         assign off_o[k] = quo[CNT_W-1:0];
      end
   end

   assign run_o  = run_q;
   assign mcnt_o = m_q;
   assign per_o  = per_q;
   assign nch_o  = n_q;

   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> (m_q < per_q)) else $error("master count out of range"); // R3

   AST_PERIOD_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q || wrap) |-> (period_i >= CNT_W'(MIN_PERIOD))) else $error("period too short"); // R3

   AST_NCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> $stable(nch_o)) else $error("channel count moved"); // R2

endmodule

// File: rtl/mpwm_duty_sat.sv
module mpwm_duty_sat #(
   parameter int CNT_W  = 8,
   parameter int CORR_W = 6
) (
   input  logic [CNT_W-1:0]  cmd_i,
   input  logic [CORR_W-1:0] corr_i,
   input  logic [CNT_W-1:0]  per_i,
   output logic [CNT_W-1:0]  duty_o
);

   localparam int SW = CNT_W + 2;

   logic signed [SW-1:0] cmd_s;
   logic signed [SW-1:0] corr_s;
   logic signed [SW-1:0] per_s;
   logic signed [SW-1:0] sum;

   always_comb begin
      cmd_s  = $signed({2'b00, cmd_i});
      corr_s = $signed({{(SW - CORR_W){corr_i[CORR_W-1]}}, corr_i});
      per_s  = $signed({2'b00, per_i});
      sum    = cmd_s + corr_s;
      if (sum < 0) begin
         duty_o = '0;
      end else if (sum >= per_s) begin
         duty_o = per_i - CNT_W'(1);
      end else begin
         duty_o = sum[CNT_W-1:0];
      end
      if (per_i >= CNT_W'(2)) begin
         AST_SAT_RANGE: assert (duty_o < per_i) else $error("duty beyond period"); // R6
      end
   end

endmodule

// File: rtl/mpwm_chan.sv
module mpwm_chan
   import mpwm_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             active_i,
   input  logic             force_low_i,
   input  logic [CNT_W-1:0] mcnt_i,
   input  logic [CNT_W-1:0] per_i,
   input  logic [CNT_W-1:0] off_i,
   input  logic [CNT_W-1:0] duty_i,
   output logic             pwm_o,
   output logic             oe_o
);

   logic [CNT_W:0]   lc_ext;
   logic [CNT_W-1:0] lc;
   logic             last;
   logic [CNT_W-1:0] duty_q;
   drv_mode_e        mode;

   // local count = (master - lag) mod period
   always_comb begin
      if (mcnt_i >= off_i) begin
         lc_ext = {1'b0, mcnt_i} - {1'b0, off_i};
      end else begin
         lc_ext = {1'b0, mcnt_i} + {1'b0, per_i} - {1'b0, off_i};
      end
      lc   = lc_ext[CNT_W-1:0];
      last = (lc == per_i - CNT_W'(1));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         duty_q <= '0;
      end else if (!run_i || last) begin
         duty_q <= duty_i;
      end
   end

   always_comb begin
      if (!rst_n || !run_i || !active_i) begin
         mode = DRV_FLOAT;
      end else if (force_low_i) begin
         mode = DRV_LOW;
      end else begin
         mode = DRV_PWM;
      end
   end

   always_comb begin
      case (mode)
         DRV_PWM: begin
            oe_o  = 1'b1;
            pwm_o = (lc < duty_q);
         end
         DRV_LOW: begin
            oe_o  = 1'b1;
            pwm_o = 1'b0;
         end
         default: begin
            oe_o  = 1'b0;
            pwm_o = 1'b0;
         end
      endcase
   end

   AST_LOCAL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && active_i) |-> (lc < per_i)) else $error("local count out of range"); // R4

   AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !last) |=> $stable(duty_q)) else $error("duty changed mid-period"); // R7

   AST_ZERO_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (duty_q == '0) |-> !pwm_o) else $error("pulse with zero duty"); // R6

endmodule

// File: rtl/mphase_pwm.sv
module mphase_pwm
   import mpwm_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int CNT_W  = 8,
   parameter int CORR_W = 6,
   localparam int CW    = $clog2(NUM_CH + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     en_i,
   input  logic                     force_low_i,
   input  logic [CNT_W-1:0]         period_i,
   input  logic [CNT_W-1:0]         duty_cmd_i,
   input  logic [NUM_CH*CORR_W-1:0] duty_corr_i,
   input  logic [NUM_CH-1:0]        tied_hi_i,
   output logic [NUM_CH-1:0]        pwm_o,
   output logic [NUM_CH-1:0]        pwm_oe_o,
   output logic                     cyc_start_o,
   output logic [CW-1:0]            nch_o
);

   if (NUM_CH < MIN_CH || NUM_CH > MAX_CH) begin : g_bad_ch
      $error("NUM_CH must lie in 2..4");
   end
   if (CNT_W < 3) begin : g_bad_cnt
      $error("CNT_W must be at least 3");
   end
   if (CORR_W < 2 || CORR_W > CNT_W) begin : g_bad_corr
      $error("CORR_W must lie in 2..CNT_W");
   end

   logic                          run;
   logic [CNT_W-1:0]              mcnt;
   logic [CNT_W-1:0]              per;
   logic [CW-1:0]                 nch;
   logic [NUM_CH-1:0][CNT_W-1:0]  off;

   mpwm_phase_ctl #(
      .NUM_CH (NUM_CH),
      .CNT_W  (CNT_W)
   ) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_i     (en_i),
      .period_i (period_i),
      .tied_i   (tied_hi_i),
      .run_o    (run),
      .mcnt_o   (mcnt),
      .per_o    (per),
      .nch_o    (nch),
      .off_o    (off)
   );

   for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
      logic [CNT_W-1:0] duty;
      logic             active;

      assign active = (CW'(k) < nch);

      mpwm_duty_sat #(
         .CNT_W  (CNT_W),
         .CORR_W (CORR_W)
      ) u_sat (
         .cmd_i  (duty_cmd_i),
         .corr_i (duty_corr_i[k*CORR_W +: CORR_W]),
         .per_i  (per),
         .duty_o (duty)
      );

      mpwm_chan #(
         .CNT_W (CNT_W)
      ) u_chan (
         .clk         (clk),
         .rst_n       (rst_n),
         .run_i       (run),
         .active_i    (active),
         .force_low_i (force_low_i),
         .mcnt_i      (mcnt),
         .per_i       (per),
         .off_i       (off[k]),
         .duty_i      (duty),
         .pwm_o       (pwm_o[k]),
         .oe_o        (pwm_oe_o[k])
      );

      AST_UNUSED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
         (CW'(k) >= nch_o) |-> (!pwm_oe_o[k] && !pwm_o[k])) else $error("unused line driven"); // R10
   end

   assign cyc_start_o = rst_n & run & (mcnt == '0);
   assign nch_o       = nch;

   AST_OE_GATES_PWM: assert property (@(posedge clk) disable iff (!rst_n)
      ((pwm_o & ~pwm_oe_o) == '0)) else $error("line high while floating"); // R8

   AST_FORCE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      force_low_i |-> (pwm_o == '0)) else $error("pulse in forced-low mode"); // R9

   AST_START_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_start_o |-> pwm_oe_o[0]) else $error("start strobe while idle"); // R3

   always @(posedge clk) begin
      if (!rst_n) begin
         AST_RESET_FLOAT: assert (pwm_oe_o == '0 && pwm_o == '0) else $error("driven in reset"); // R8
      end
   end

endmodule

// File: tb/mphase_pwm_test.sv
`timescale 1ns/1ps
module mphase_pwm_test;

   typedef struct packed {
      logic [3:0]  tied;
      logic [7:0]  per;
      logic [7:0]  cmd;
      logic [23:0] corr;
   } vec_t;

   // corrections packed {c3,c2,c1,c0}, 6-bit two's complement
   localparam vec_t VECS [6] = '{
      '{4'b0000, 8'd16, 8'd6, {6'h00, 6'h00, 6'h00, 6'h00}},
      '{4'b1000, 8'd12, 8'd5, {6'h00, 6'h3E, 6'h00, 6'h01}},
      '{4'b1100, 8'd10, 8'd3, {6'h00, 6'h00, 6'h02, 6'h00}},
      '{4'b0000, 8'd8,  8'd7, {6'h3D, 6'h05, 6'h00, 6'h3F}},
      '{4'b1000, 8'd10, 8'd2, {6'h00, 6'h3B, 6'h3F, 6'h03}},
      '{4'b0100, 8'd9,  8'd4, {6'h00, 6'h00, 6'h00, 6'h00}}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0;
   logic        force_low = 1'b0;
   logic [7:0]  period = 8'd16;
   logic [7:0]  cmd = 8'd0;
   logic [23:0] corr = '0;
   logic [3:0]  tied = 4'b0000;
   logic [3:0]  pwm;
   logic [3:0]  oe;
   logic        start;
   logic [2:0]  nch;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;
   int cur_p;
   int cur_n;
   int t;
   int dexp [4];
   bit fresh;

   always #2 clk = ~clk;

   mphase_pwm uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .en_i        (en),
      .force_low_i (force_low),
      .period_i    (period),
      .duty_cmd_i  (cmd),
      .duty_corr_i (corr),
      .tied_hi_i   (tied),
      .pwm_o       (pwm),
      .pwm_oe_o    (oe),
      .cyc_start_o (start),
      .nch_o       (nch)
   );

   function automatic int f_n(logic [3:0] td);
      if (td[2]) return 2;
      if (td[3]) return 3;
      return 4;
   endfunction

   function automatic int f_sat(int c, logic [23:0] cr, int k, int p);
      int s;
      s = c + int'($signed(cr[k*6 +: 6]));
      if (s < 0) return 0;
      if (s > p - 1) return p - 1;
      return s;
   endfunction

   function automatic int f_lc(int k, int tt);
      int m;
      int off;
      m   = tt % cur_p;
      off = (k * cur_p) / cur_n;
      return (m + cur_p - off) % cur_p;
   endfunction

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s t=%0d actual=%0d expected=%0d", req, t, act, exp);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      end
   endtask

   task automatic start_run(vec_t v);
      @(negedge clk);
      rst_n = 1'b0;
      en = 1'b0;
      force_low = 1'b0;
      tied = v.tied;
      period = v.per;
      cmd = v.cmd;
      corr = v.corr;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      en = 1'b1;
      cur_p = int'(v.per);
      cur_n = f_n(v.tied);
      for (int k = 0; k < 4; k++) dexp[k] = f_sat(int'(cmd), corr, k, cur_p);
      t = 0;
      fresh = 1'b1;
   endtask

   // model: latch happens on the edge after a sample whose local count is P-1
   task automatic run_cycles(int nc);
      for (int i = 0; i < nc; i++) begin
         int ep;
         int eo;
         if (!fresh) begin
            for (int k = 0; k < 4; k++) begin
               if (k < cur_n && f_lc(k, t) == cur_p - 1) dexp[k] = f_sat(int'(cmd), corr, k, cur_p);
            end
            t++;
         end
         fresh = 1'b0;
         @(negedge clk);
         ep = 0;
         eo = 0;
         for (int k = 0; k < 4; k++) begin
            if (k < cur_n) eo |= (1 << k);
            if (k < cur_n && !force_low && f_lc(k, t) < dexp[k]) ep |= (1 << k);
         end
         chk("R4 R5 R6 R7 R9 pwm", int'(pwm), ep);
         chk("R9 R10 oe", int'(oe), eo);
         chk("R3 start", int'(start), (t % cur_p == 0) ? 1 : 0);
         chk("R1 R2 nch", int'(nch), cur_n);
      end
   endtask

   initial begin
      #(4 * 100000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=0 expected=1");
         summary();
         $finish;
      end
   end

   initial begin
      // reset state: floating lines, count from tied flags (R8, R1)
      tied = 4'b1000;
      repeat (3) @(negedge clk);
      chk("R8 reset oe", int'(oe), 0);
      chk("R8 reset pwm", int'(pwm), 0);
      chk("R1 reset nch", int'(nch), 3);

      // table of configurations
      for (int v = 0; v < 6; v++) begin
         start_run(VECS[v]);
         run_cycles(3 * cur_p + 2);
      end

      // R2: tied flags change while running, count holds
      start_run(VECS[0]);
      run_cycles(5);
      tied = 4'b1100;
      run_cycles(20);

      // R7: new command mid-period, each channel picks it up at its own wrap
      cmd = 8'd10;
      run_cycles(2 * cur_p);
      cmd = 8'd0;
      run_cycles(2 * cur_p);

      // R9: forced low keeps active lines driven low
      cmd = 8'd9;
      run_cycles(cur_p);
      force_low = 1'b1;
      run_cycles(cur_p);
      force_low = 1'b0;
      run_cycles(4);

      // R8: disable floats everything
      en = 1'b0;
      @(negedge clk);
      chk("R8 disabled oe", int'(oe), 0);
      chk("R8 disabled pwm", int'(pwm), 0);
      chk("R3 disabled start", int'(start), 0);

      // R8: reset mid-run releases lines at once
      start_run(VECS[1]);
      run_cycles(7);
      rst_n = 1'b0;
      #1;
      chk("R8 reset mid-run oe", int'(oe), 0);
      chk("R8 reset mid-run pwm", int'(pwm), 0);
      repeat (2) @(negedge clk);

      summary();
      $finish;
   end

endmodule